// File: doc/BRIEF.md
# Configurable LUT Logic Cell

A behavioural model of a single programmable logic cell. The cell holds two three-input lookup tables, called X and Y. Their third address input comes from a W-source mux. A register-input selector feeds a storage flop. The flop can be forced to a configured value by a set/reset pulse. Two bypass switches can route the selector output around the flop, onto the center node or onto the feedback line. The center node is gated onto the two outward outputs.

All behaviour is programmed through an octet-wide write port. Each write carries an 8-bit selector and an 8-bit data octet. Only selectors whose upper nibble is zero belong to this cell. The lower nibble picks one of four storage octets:

- the control octet at 0x1
- the X table at 0x6
- the Y table at 0x7
- the mode octet at 0xA

The tables are stored as the complement of the intended truth table. An active-low clear empties all configuration storage and the flop.

Top module: `lut_logic_cell`

## Requirements
- R1: A write to selector 0x06 (X) or 0x07 (Y) stores an octet. The table output is the inverse of bit {wmux, in_y, in_x} of that octet. in_x is the least significant bit of that index.
- R2: The W-source mux works by priority. If control bit 5 is set, it outputs in_w AND in_z. Otherwise, if control bit 4 is set, it outputs the register value. Otherwise it outputs in_w.
- R3: The register-input selector works by priority. If control bit 7 is set, it passes in_z. Otherwise, if control bit 6 is set, it passes the Y table output. Otherwise it passes the X table output.
- R4: If control bit 3 is set, the center node carries the selector output; otherwise it carries the register. Bit 2 makes the same choice for the fb output.
- R5: xo equals the center node when control bit 1 is set, else 0. yo equals the center node when control bit 0 is set, else 0.
- R6: While reg_sr is high at a clock edge, the register loads 1 if mode bit 0 is 0, or 0 if mode bit 0 is 1. This takes precedence over the selector.
- R7: A write whose selector has a nonzero upper nibble changes no storage. A write to an unassigned lower nibble also changes no storage.
- R8: While cfg_clr_n is low, all configuration bits and the register clear. Both tables then output 1, and xo, yo and fb read 0.
- R9: A configuration write takes effect at the clock edge on which cfg_we is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration storage and register |
| cfg_clr_n | input | 1 | Asynchronous active-low clear of configuration and register |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 8 | Resource selector of the write |
| cfg_data | input | 8 | Data octet of the write |
| in_x | input | 1 | Cell input X (table address bit 0) |
| in_y | input | 1 | Cell input Y (table address bit 1) |
| in_w | input | 1 | Cell input W |
| in_z | input | 1 | Cell input Z |
| reg_sr | input | 1 | Synchronous register set/reset pulse |
| xo | output | 1 | Gated center node, X side |
| yo | output | 1 | Gated center node, Y side |
| fb | output | 1 | Feedback line |

## Verification
The bench builds the cell with its default parameters: three table inputs, which gives eight-entry tables, and octet-wide selector and data. With eight entries, every table address can be reached quickly. Random writes that mix the four assigned selectors with arbitrary bytes therefore cover every control-bit combination, including both mux priority collisions, within a few thousand cycles. Directed steps pin the index bit order, the reset-state constants and the set/reset polarity.

// File: rtl/cell_pkg.sv
package cell_pkg;
    parameter int LUT_IN   = 3;
    parameter int OCT_W    = 8;
    parameter int SEL_W    = 8;
    localparam int LUT_BITS = 1 << LUT_IN;
    localparam int NIB_W    = SEL_W / 2;

    localparam logic [NIB_W-1:0] SEL_CTL  = 4'h1;
    localparam logic [NIB_W-1:0] SEL_XTAB = 4'h6;
    localparam logic [NIB_W-1:0] SEL_YTAB = 4'h7;
    localparam logic [NIB_W-1:0] SEL_MODE = 4'hA;

    // control octet bit positions
    localparam int CB_Z_REG   = 7;
    localparam int CB_Y_REG   = 6;
    localparam int CB_WZ_WM   = 5;
    localparam int CB_FB_WM   = 4;
    localparam int CB_BYP_C   = 3;
    localparam int CB_BYP_FB  = 2;
    localparam int CB_C_XO    = 1;
    localparam int CB_C_YO    = 0;
    // mode octet bit position
    localparam int MB_SR_POL  = 0;

    typedef struct packed {
        logic [OCT_W-1:0]    ctl;
        logic [OCT_W-1:0]    mode;
        logic [LUT_BITS-1:0] xtab;
        logic [LUT_BITS-1:0] ytab;
    } cell_cfg_t;
endpackage

// File: rtl/cell_cfg_store.sv
module cell_cfg_store
    import cell_pkg::*;
(
    input  logic             clk,
    input  logic             clr_n,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic [OCT_W-1:0] data,
    output cell_cfg_t        cfg
);
    cell_cfg_t cfg_d, cfg_q;
    logic      local_hit;

    assign local_hit = we && (sel[SEL_W-1:NIB_W] == '0);

    always_comb begin
        cfg_d = cfg_q;
        if (local_hit) begin
            unique case (sel[NIB_W-1:0])
                SEL_CTL:  cfg_d.ctl  = data;
                SEL_MODE: cfg_d.mode = data;
                SEL_XTAB: cfg_d.xtab = data[LUT_BITS-1:0];
                SEL_YTAB: cfg_d.ytab = data[LUT_BITS-1:0];
                default:  cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    // R7
    foreign_write_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (we && sel[SEL_W-1:NIB_W] != '0) |=> $stable(cfg_q));
    // R9
    ctl_write_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (we && sel == {{NIB_W{1'b0}}, SEL_CTL}) |=> (cfg_q.ctl == $past(data)));
endmodule

// File: rtl/cell_lut.sv
module cell_lut
    import cell_pkg::*;
(
    input  logic [LUT_BITS-1:0] tab_inv,
    input  logic [LUT_IN-1:0]   addr,
    output logic                q
);
    assign q = ~tab_inv[addr];
endmodule

// File: rtl/cell_core.sv
module cell_core
    import cell_pkg::*;
(
    input  logic             clk,
    input  logic             clr_n,
    input  logic [OCT_W-1:0] ctl,
    input  logic [OCT_W-1:0] mode,
    input  logic             xl,
    input  logic             yl,
    input  logic             in_w,
    input  logic             in_z,
    input  logic             reg_sr,
    output logic             wm,
    output logic             xo,
    output logic             yo,
    output logic             fb
);
    logic reg_d, reg_q;
    logic rin, ctr;

    always_comb begin
        // W-source mux, priority WZ then feedback (registered to break the loop)
        if (ctl[CB_WZ_WM])      wm = in_w & in_z;
        else if (ctl[CB_FB_WM]) wm = reg_q;
        else                    wm = in_w;
        // register-input selector
        if (ctl[CB_Z_REG])      rin = in_z;
        else if (ctl[CB_Y_REG]) rin = yl;
        else                    rin = xl;
        // next register value
        if (reg_sr) reg_d = ~mode[MB_SR_POL];
        else        reg_d = rin;
        ctr = ctl[CB_BYP_C]  ? rin : reg_q;
        fb  = ctl[CB_BYP_FB] ? rin : reg_q;
        xo  = ctl[CB_C_XO] & ctr;
        yo  = ctl[CB_C_YO] & ctr;
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) reg_q <= 1'b0;
        else        reg_q <= reg_d;
    end

    // R6
    sr_set_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (reg_sr && !mode[MB_SR_POL]) |=> reg_q);
    // R6
    sr_clear_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (reg_sr && mode[MB_SR_POL]) |=> !reg_q);
    // R4
    fb_bypass_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (ctl[CB_BYP_FB] && !reg_sr) |=> (reg_q == $past(fb)));
    // R5
    xo_gate_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !ctl[CB_C_XO] |-> !xo);
endmodule

// File: rtl/lut_logic_cell.sv
module lut_logic_cell
    import cell_pkg::*;
(
    input  logic             clk,
    input  logic             cfg_clr_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [OCT_W-1:0] cfg_data,
    input  logic             in_x,
    input  logic             in_y,
    input  logic             in_w,
    input  logic             in_z,
    input  logic             reg_sr,
    output logic             xo,
    output logic             yo,
    output logic             fb
);
    localparam int N_TAB = 2;

    cell_cfg_t             cfg;
    logic                  wm;
    logic [N_TAB-1:0]      tab_q;
    logic [LUT_BITS-1:0]   tabs [N_TAB];
    logic [LUT_IN-1:0]     taddr;

    assign tabs[0] = cfg.xtab;
    assign tabs[1] = cfg.ytab;
    assign taddr   = {wm, in_y, in_x};

    cell_cfg_store u_cfg (
        .clk   (clk),
        .clr_n (cfg_clr_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .data  (cfg_data),
        .cfg   (cfg)
    );

    for (genvar t = 0; t < N_TAB; t++) begin : g_tab
        cell_lut u_lut (
            .tab_inv (tabs[t]),
            .addr    (taddr),
            .q       (tab_q[t])
        );
    end

    cell_core u_core (
        .clk    (clk),
        .clr_n  (cfg_clr_n),
        .ctl    (cfg.ctl),
        .mode   (cfg.mode),
        .xl     (tab_q[0]),
        .yl     (tab_q[1]),
        .in_w   (in_w),
        .in_z   (in_z),
        .reg_sr (reg_sr),
        .wm     (wm),
        .xo     (xo),
        .yo     (yo),
        .fb     (fb)
    );
endmodule

// File: tb/sim_lut_logic_cell.sv
`timescale 1ns/1ps
module sim_lut_logic_cell;
    logic clk = 0, cfg_clr_n = 0, cfg_we = 0;
    logic [7:0] cfg_sel = 0, cfg_data = 0;
    logic in_x = 0, in_y = 0, in_w = 0, in_z = 0, reg_sr = 0;
    logic xo, yo, fb;
    int n_chk = 0, n_fail = 0;

    // model state
    logic [7:0] m_ctl = 0, m_mode = 0, m_xt = 0, m_yt = 0;
    logic m_reg = 0;

    always #2 clk = ~clk;

    lut_logic_cell u0 (.clk(clk), .cfg_clr_n(cfg_clr_n), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_data(cfg_data), .in_x(in_x), .in_y(in_y),
        .in_w(in_w), .in_z(in_z), .reg_sr(reg_sr), .xo(xo), .yo(yo), .fb(fb));

    function automatic logic f_wm();
        if (m_ctl[5]) return in_w & in_z;
        if (m_ctl[4]) return m_reg;
        return in_w;
    endfunction
    function automatic logic f_rin();
        logic [2:0] a;
        a = {f_wm(), in_y, in_x};
        if (m_ctl[7]) return in_z;
        if (m_ctl[6]) return ~m_yt[a];
        return ~m_xt[a];
    endfunction
    function automatic logic f_ctr();
        return m_ctl[3] ? f_rin() : m_reg;
    endfunction

    task automatic check(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        check({tag, " xo R5"}, xo, m_ctl[1] & f_ctr());
        check({tag, " yo R5"}, yo, m_ctl[0] & f_ctr());
        check({tag, " fb R4"}, fb, m_ctl[2] ? f_rin() : m_reg);
    endtask

    task automatic tick();
        logic nr;
        logic [7:0] c, md, xt, yt;
        nr = reg_sr ? ~m_mode[0] : f_rin();
        c = m_ctl; md = m_mode; xt = m_xt; yt = m_yt;
        if (cfg_we && cfg_sel[7:4] == 4'h0) begin
            case (cfg_sel[3:0])
                4'h1: c  = cfg_data;
                4'hA: md = cfg_data;
                4'h6: xt = cfg_data;
                4'h7: yt = cfg_data;
                default: ;
            endcase
        end
        @(posedge clk);
        m_reg = nr; m_ctl = c; m_mode = md; m_xt = xt; m_yt = yt;
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] s, logic [7:0] d);
        cfg_we = 1; cfg_sel = s; cfg_data = d;
        tick();
        cfg_we = 0;
    endtask

    task automatic set_in(logic x, logic y, logic w, logic z);
        in_x = x; in_y = y; in_w = w; in_z = z;
        #1;
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        #1;
        // R8: cleared state
        check("R8 xo", xo, 1'b0);
        check("R8 yo", yo, 1'b0);
        check("R8 fb", fb, 1'b0);
        cfg_clr_n = 1;
        @(negedge clk);
        // R8: cleared tables read 1; R9 write lands at the edge
        wr(8'h01, 8'h0A);
        #1;
        check("R9 R8 table constant one", xo, 1'b1);
        // R1: truth table 1 only at index 4 (w=1,y=0,x=0)
        wr(8'h06, 8'hEF);
        set_in(0, 0, 1, 0); check("R1 index4", xo, 1'b1);
        set_in(0, 0, 0, 0); check("R1 index0", xo, 1'b0);
        set_in(1, 0, 1, 0); check("R1 index5", xo, 1'b0);
        // R2: W AND Z drives the third input
        wr(8'h01, 8'h2A);
        set_in(0, 0, 1, 0); check("R2 wz low", xo, 1'b0);
        set_in(0, 0, 1, 1); check("R2 wz high", xo, 1'b1);
        // R3: Z drives the register input, then Y table
        wr(8'h01, 8'h8A);
        set_in(0, 0, 0, 1); check("R3 z one", xo, 1'b1);
        set_in(0, 0, 0, 0); check("R3 z zero", xo, 1'b0);
        wr(8'h07, 8'h00);
        wr(8'h01, 8'h4A);
        #1; check("R3 y table", xo, 1'b1);
        // R6: set then reset polarity through the register path
        wr(8'h06, 8'hFF);
        wr(8'h01, 8'h03);
        wr(8'h0A, 8'h00);
        reg_sr = 1; tick(); reg_sr = 0; #1;
        check("R6 set", xo, 1'b1);
        check("R6 set yo", yo, 1'b1);
        wr(8'h0A, 8'h01);
        wr(8'h06, 8'h00);
        reg_sr = 1; tick(); reg_sr = 0; #1;
        check("R6 reset over data", xo, 1'b0);
        // R7: foreign and unassigned writes leave tables alone
        wr(8'h01, 8'h0A);
        wr(8'h06, 8'hEF);
        set_in(0, 0, 1, 0);
        wr(8'h16, 8'hFF);
        wr(8'h05, 8'hFF);
        #1; check("R7 foreign ignored", xo, 1'b1);
        wr(8'h91, 8'h00);
        #1; check("R7 control kept", xo, 1'b1);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            int k;
            k = $urandom % 6;
            cfg_we = (k != 5);
            case (k)
                0: cfg_sel = 8'h01;
                1: cfg_sel = 8'h06;
                2: cfg_sel = 8'h07;
                3: cfg_sel = 8'h0A;
                default: cfg_sel = 8'($urandom);
            endcase
            cfg_data = 8'($urandom);
            reg_sr = ($urandom % 8) == 0;
            set_in(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            check_all("random R1 R2 R3");
            tick();
        end
        cfg_we = 0; reg_sr = 0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule